// File: doc/BRIEF.md
# Halfword multiply-accumulate unit

This block is the halfword multiply-accumulate datapath of a 32-bit integer pipeline. Each issued operation picks one 16-bit half of each of two source words. It extends each half as signed or unsigned and multiplies them. It then writes either the bare product, or the accumulator plus the product, or the accumulator minus the product. The decoder of the surrounding pipeline presents the operation as a five-bit select code plus three control bits: accumulate, negate and record.

In the accumulating forms the unit can check for overflow, under signed or unsigned rules. It can also clamp the result to the limit of the chosen number range. A check updates the overflow flag and the sticky summary-overflow flag. When the record bit is set, the unit also produces a four-bit condition field that describes the final value.

The arithmetic is one combinational stage followed by one register stage. A valid strobe goes in with the operands. The result, the flags and the condition field appear one clock later.

Top module: `hmac_mac_unit`

## Requirements
- R1: sel_code bit 2 picks the half of src_a and bit 3 picks the half of src_b: 1 selects bits [15:0], 0 selects bits [31:16]. Codes 0x05/0x04 pair the low half of src_a with the high half of src_b, codes 0x01/0x00 pair the high halves, and codes 0x0D/0x0C pair the low halves.
- R2: sel_code bit 0 = 1 sign-extends each selected half before the multiply and bit 0 = 0 zero-extends it. The product is the low 32 bits of the extended operands multiplied together.
- R3: With acc_en = 0 the product is written to result unchanged, whatever sel_code bits 4 and 1 say. In that case ov_out equals ov_in and so_out equals so_in.
- R4: With acc_en = 1 the result is acc_in + product. With acc_en = 1 and neg_en = 1 it is acc_in - product.
- R5: When sel_code bit 0 = 1, overflow means the exact signed sum or difference falls outside the 32-bit two's-complement range. With bit 4 = 1 a signed overflow sets both ov_out and so_out, and an unclamped result wraps.
- R6: When sel_code bits 1 and 0 are both 1 and a signed overflow occurs, the result is 0x7FFFFFFF if acc_in was non-negative and 0x80000000 if acc_in was negative.
- R7: When sel_code bit 0 = 0, overflow means a carry out of the add, or a borrow out of the subtract (acc_in < product). With sel_code bit 1 = 1 such an overflow clamps the result to 0xFFFFFFFF.
- R8: With acc_en = 1 and sel_code bit 4 = 1, ov_out is 1 only on overflow and is 0 otherwise. so_out is so_in OR the overflow, so it is never cleared.
- R9: cr_we is rec_en of the same operation. cr_out is {lt, gt, eq, so}, bit 3 down to bit 0. lt, gt and eq compare the final result as a signed number with zero, and so equals the new so_out.
- R10: Every operation with in_valid = 1 yields out_valid = 1 and its outputs exactly one clock later. out_valid is 0 one clock after in_valid = 0, and all outputs are 0 after reset.
- R11: With sel_code bit 1 = 1 and bit 4 = 0, an overflow still clamps the result, but ov_out and so_out keep ov_in and so_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_in | input | 32 | Current accumulator (destination) value |
| sel_code | input | 5 | Half select, signedness, saturate and overflow-check bits |
| acc_en | input | 1 | Accumulate the product into acc_in |
| neg_en | input | 1 | Subtract instead of add when accumulating |
| rec_en | input | 1 | Request a condition-field update |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current sticky summary-overflow flag |
| out_valid | output | 1 | Outputs belong to an operation issued last cycle |
| result | output | 32 | New destination value |
| ov_out | output | 1 | New overflow flag |
| so_out | output | 1 | New summary-overflow flag |
| cr_out | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we | output | 1 | Condition field write enable |

## Verification
The hardest cases to reach are the overflow corners. They need an accumulator placed next to a range limit, together with a product large enough and of the right sign to cross it. The hardest of all is the unsigned subtract that borrows and clamps to all ones. The bench drives acc_in directly to values such as 0x7FFFFFF0, 0x80000010 and 0xFFFFFFF0, and pairs them with half-word operands chosen so that the product crosses the limit by a known amount. It also covers products that only just miss overflow, and the case where the check bit is set but no overflow occurs while ov_in is 1, so that the clearing of the flag is seen at the ports.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic a_low;     // take low half of src_a
    logic b_low;     // take low half of src_b
    logic signed_op; // signed extension and signed overflow rules
    logic sat;       // clamp on overflow
    logic chk;       // update overflow flags
  } hmac_mode_t;

  function automatic hmac_mode_t hmac_decode(input logic [CODE_W-1:0] code);
    hmac_mode_t m;
    m.a_low     = code[2];
    m.b_low     = code[3];
    m.signed_op = code[0];
    m.sat       = code[1];
    m.chk       = code[4];
    return m;
  endfunction
endpackage

// File: rtl/hmac_operand_sel.sv
module hmac_operand_sel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] word,
  input  logic            pick_low,
  input  logic            sign_ext,
  output logic [XLEN-1:0] ext
);
  localparam int HALF = XLEN / 2;

  logic [HALF-1:0] half;

  always_comb begin
    half = pick_low ? word[HALF-1:0] : word[XLEN-1:HALF];
    if (sign_ext) ext = {{(XLEN-HALF){half[HALF-1]}}, half};
    else          ext = {{(XLEN-HALF){1'b0}}, half};
  end
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum
  import hmac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] acc,
  input  logic [XLEN-1:0] prod,
  input  logic            acc_en,
  input  logic            neg_en,
  input  hmac_mode_t      mode,
  output logic [XLEN-1:0] value,
  output logic            ovf
);
  localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] UMAX = {XLEN{1'b1}};

  logic [XLEN:0]   raw;
  logic [XLEN-1:0] wrapped;
  logic            s_ovf;
  logic            u_ovf;

  always_comb begin
    if (neg_en) raw = {1'b0, acc} - {1'b0, prod};
    else        raw = {1'b0, acc} + {1'b0, prod};
    wrapped = raw[XLEN-1:0];
    // signed: addend is product, or its negation when subtracting
    if (neg_en) s_ovf = (acc[XLEN-1] != prod[XLEN-1]) && (wrapped[XLEN-1] != acc[XLEN-1]);
    else        s_ovf = (acc[XLEN-1] == prod[XLEN-1]) && (wrapped[XLEN-1] != acc[XLEN-1]);
    // unsigned: carry out of add, borrow out of subtract
    u_ovf = raw[XLEN];
    ovf   = acc_en && (mode.signed_op ? s_ovf : u_ovf);

    if (!acc_en) begin
      value = prod;
    end else if (ovf && mode.sat) begin
      if (mode.signed_op) value = {XLEN{acc[XLEN-1]}} ^ SMAX;
      else                value = UMAX;
    end else begin
      value = wrapped;
    end
  end
endmodule

// File: rtl/hmac_mac_unit.sv
module hmac_mac_unit
  import hmac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [XLEN-1:0]   acc_in,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              acc_en,
  input  logic              neg_en,
  input  logic              rec_en,
  input  logic              ov_in,
  input  logic              so_in,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic              ov_out,
  output logic              so_out,
  output logic [3:0]        cr_out,
  output logic              cr_we
);
  localparam int NOPS = 2;
  localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] UMAX = {XLEN{1'b1}};

  hmac_mode_t      mode;
  logic [XLEN-1:0] src_w [NOPS];
  logic            low_w [NOPS];
  logic [XLEN-1:0] opnd  [NOPS];
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] value;
  logic            ovf;
  logic            ov_nx;
  logic            so_nx;
  logic [3:0]      cr_nx;

  always_comb begin
    mode     = hmac_decode(sel_code);
    src_w[0] = src_a;
    src_w[1] = src_b;
    low_w[0] = mode.a_low;
    low_w[1] = mode.b_low;
  end

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_opnd
    hmac_operand_sel #(.XLEN(XLEN)) u_sel (
      .word     (src_w[gi]),
      .pick_low (low_w[gi]),
      .sign_ext (mode.signed_op),
      .ext      (opnd[gi])
    );
  end

  always_comb prod = opnd[0] * opnd[1];

  hmac_accum #(.XLEN(XLEN)) u_acc (
    .acc    (acc_in),
    .prod   (prod),
    .acc_en (acc_en),
    .neg_en (neg_en),
    .mode   (mode),
    .value  (value),
    .ovf    (ovf)
  );

  always_comb begin
    if (acc_en && mode.chk) begin
      ov_nx = ovf;
      so_nx = so_in | ovf;
    end else begin
      ov_nx = ov_in;
      so_nx = so_in;
    end
    cr_nx[3] = value[XLEN-1];
    cr_nx[2] = !value[XLEN-1] && (value != '0);
    cr_nx[1] = (value == '0);
    cr_nx[0] = so_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ov_out    <= 1'b0;
      so_out    <= 1'b0;
      cr_out    <= '0;
      cr_we     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      cr_we     <= in_valid && rec_en;
      if (in_valid) begin
        result <= value;
        ov_out <= ov_nx;
        so_out <= so_nx;
        cr_out <= cr_nx;
      end
    end
  end

  // R10
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  idle_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && so_in |=> so_out);
  // R8
  ov_sets_so_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_en && sel_code[4] |=> (!ov_out || so_out));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !acc_en |=> (ov_out == $past(ov_in)) && (so_out == $past(so_in)));
  // R6
  signed_sat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_en && sel_code[4] && sel_code[1] && sel_code[0]
    |=> (!ov_out || result == SMAX || result == SMIN));
  // R7
  unsigned_sat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_en && sel_code[4] && sel_code[1] && !sel_code[0]
    |=> (!ov_out || result == UMAX));
  // R9
  cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && cr_we |-> ($countones(cr_out[3:1]) == 1) && (cr_out[0] == so_out));
endmodule

// File: tb/tb_hmac_mac_unit.sv
module tb_hmac_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
  logic [4:0]  sel_code = '0;
  logic        acc_en = 1'b0, neg_en = 1'b0, rec_en = 1'b0, ov_in = 1'b0, so_in = 1'b0;
  logic        out_valid, ov_out, so_out, cr_we;
  logic [31:0] result;
  logic [3:0]  cr_out;

  hmac_mac_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .sel_code(sel_code), .acc_en(acc_en), .neg_en(neg_en),
    .rec_en(rec_en), .ov_in(ov_in), .so_in(so_in), .out_valid(out_valid),
    .result(result), .ov_out(ov_out), .so_out(so_out), .cr_out(cr_out), .cr_we(cr_we)
  );

  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic        ov;
    logic        so;
    logic [3:0]  cr;
    logic        we;
    int          issue;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic item_t model(input string tag, input logic [31:0] a, b, acc,
                                  input logic [4:0] code, input logic ae, ng, rc, ovi, soi);
    item_t it;
    logic [15:0] ha, hb;
    longint sa, sb, p, accv, tot;
    logic [31:0] p32;
    bit over;
    ha = code[2] ? a[15:0] : a[31:16];
    hb = code[3] ? b[15:0] : b[31:16];
    sa = code[0] ? longint'($signed(ha)) : longint'(ha);
    sb = code[0] ? longint'($signed(hb)) : longint'(hb);
    p = sa * sb;
    p32 = p[31:0];
    over = 0;
    it.tag = tag;
    it.ov = ovi;
    it.so = soi;
    if (!ae) begin
      it.res = p32;
    end else begin
      if (code[0]) begin
        accv = longint'($signed(acc));
        tot = ng ? accv - longint'($signed(p32)) : accv + longint'($signed(p32));
        over = (tot > 64'sd2147483647) || (tot < -64'sd2147483648);
      end else begin
        accv = longint'(acc);
        tot = ng ? accv - longint'(p32) : accv + longint'(p32);
        over = (tot > 64'sd4294967295) || (tot < 0);
      end
      it.res = tot[31:0];
      if (over && code[1]) it.res = code[0] ? (acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : 32'hFFFF_FFFF;
      if (code[4]) begin
        it.ov = over;
        it.so = soi | over;
      end
    end
    it.cr = {$signed(it.res) < 0, $signed(it.res) > 0, it.res == 0, it.so};
    it.we = rc;
    return it;
  endfunction

  task automatic drive(input string tag, input logic [31:0] a, b, acc,
                       input logic [4:0] code, input logic ae, ng, rc, ovi, soi);
    item_t it;
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; sel_code = code;
    acc_en = ae; neg_en = ng; rec_en = rc; ov_in = ovi; so_in = soi;
    in_valid = 1'b1;
    it = model(tag, a, b, acc, code, ae, ng, rc, ovi, soi);
    it.issue = cyc;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      item_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected out_valid actual=1 expected=0");
      end else begin
        e = q.pop_front();
        if (result !== e.res || ov_out !== e.ov || so_out !== e.so ||
            cr_we !== e.we || (e.we && cr_out !== e.cr) || cyc != e.issue + 1) begin
          errors++;
          $display("FAIL %s actual res=%h ov=%b so=%b cr=%b we=%b cyc=%0d expected res=%h ov=%b so=%b cr=%b we=%b cyc=%0d",
                   e.tag, result, ov_out, so_out, cr_out, cr_we, cyc,
                   e.res, e.ov, e.so, e.cr, e.we, e.issue + 1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || cr_we !== 1'b0 || ov_out !== 1'b0 || so_out !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual v=%b res=%h we=%b expected v=0 res=0 we=0", out_valid, result, cr_we);
    end
    // R1 / R2 half pairings, multiply only
    drive("R1 lo*hi signed",   32'h1234_FFFF, 32'h0003_5555, 0, 5'h05, 0, 0, 0, 0, 0);
    drive("R2 lo*hi unsigned", 32'h1234_FFFF, 32'h0003_5555, 0, 5'h04, 0, 0, 0, 0, 0);
    drive("R1 hi*hi signed",   32'h8000_0001, 32'h8000_0002, 0, 5'h01, 0, 0, 0, 0, 0);
    drive("R2 hi*hi unsigned", 32'hFFFF_0001, 32'hFFFF_0002, 0, 5'h00, 0, 0, 0, 0, 0);
    drive("R1 lo*lo signed",   32'h7777_FFFE, 32'h1111_0007, 0, 5'h0D, 0, 0, 0, 0, 0);
    drive("R2 lo*lo unsigned", 32'h7777_FFFE, 32'h1111_0007, 0, 5'h0C, 0, 0, 0, 0, 0);
    idle(2);
    // R3 check and saturate bits ignored without accumulate
    drive("R3 product only",   32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 5'h1F, 0, 0, 0, 1, 0);
    // R4 accumulate add and subtract
    drive("R4 add",            32'h0000_0010, 32'h0000_0020, 32'h0000_1000, 5'h0D, 1, 0, 0, 0, 0);
    drive("R4 sub",            32'h0000_0010, 32'h0000_0020, 32'h0000_1000, 5'h0D, 1, 1, 0, 0, 0);
    // R5 signed overflow wraps, flags set
    drive("R5 signed ovf",     32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFF0, 5'h1D, 1, 0, 0, 0, 0);
    drive("R5 signed near",    32'h0000_0001, 32'h0000_000F, 32'h7FFF_FFF0, 5'h1D, 1, 0, 0, 0, 0);
    // R6 signed saturation both directions
    drive("R6 sat pos",        32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFF0, 5'h1F, 1, 0, 0, 0, 0);
    drive("R6 sat neg",        32'h0000_0100, 32'h0000_0100, 32'h8000_0010, 5'h1F, 1, 1, 0, 0, 0);
    drive("R6 sat pos via sub",32'h0000_FFFF, 32'h0000_0100, 32'h7FFF_FFF0, 5'h1F, 1, 1, 0, 0, 0);
    // R7 unsigned carry and borrow
    drive("R7 carry sat",      32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFF0, 5'h1E, 1, 0, 0, 0, 0);
    drive("R7 borrow sat",     32'h0000_0004, 32'h0000_0004, 32'h0000_0005, 5'h1E, 1, 1, 0, 0, 0);
    drive("R7 carry wrap",     32'h0000_0002, 32'h0000_0010, 32'hFFFF_FFF0, 5'h1C, 1, 0, 0, 0, 0);
    drive("R7 no borrow",      32'h0000_0001, 32'h0000_0005, 32'h0000_0005, 5'h1E, 1, 1, 0, 0, 0);
    idle(1);
    // R8 ov cleared when checked and clean; SO kept; unchecked passes ov
    drive("R8 ov cleared",     32'h0000_0002, 32'h0000_0003, 32'h0000_0001, 5'h1D, 1, 0, 0, 1, 1);
    drive("R8 ov unchecked",   32'h0000_0002, 32'h0000_0003, 32'h0000_0001, 5'h0D, 1, 0, 0, 1, 0);
    // R11 saturate without check
    drive("R11 sat no chk",    32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFF0, 5'h0F, 1, 0, 0, 0, 0);
    // R9 condition field
    drive("R9 cr negative",    32'h0000_FFFF, 32'h0000_0005, 0, 5'h0D, 0, 0, 1, 0, 1);
    drive("R9 cr positive",    32'h0000_0003, 32'h0000_0005, 0, 5'h0D, 0, 0, 1, 0, 0);
    drive("R9 cr zero",        32'h0000_0003, 32'h0000_0005, 32'h0000_000F, 5'h0D, 1, 1, 1, 0, 0);
    drive("R9 cr ovf so",      32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFF0, 5'h1F, 1, 0, 1, 0, 0);
    idle(3);
    // R10 every issued item observed
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending results actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule